// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block brings a set of generated clock outputs to rest, one at a time, before the clock sources are switched off. It then wakes them again without glitches. It gates a parameterized number of single-ended clocks and a parameterized number of differential groups. The default build has three differential groups: CPU at index 0, SRC at index 1 and DOT at index 2. Each differential output is a true/complement pair, and each half has its own output-enable, so either half can be tristated. The block also drives enables for the crystal oscillator and the VCO. All logic runs on one fast sampling clock. The generated clocks arrive as level inputs, and the block gates them on their way out.

A single control pin has two jobs. After reset it is an active-low power-good input. Once it has been seen low at a sampling point, it becomes an active-high power-down request for the rest of operation. Sampling points are the rising edges of the CPU complement clock, which are the falling edges of the true input of group 0. The pin is first passed through a synchronizer.

For each differential group, a mode bit chooses how the pair rests. With the bit at 0, the true output is held high and the complement is tristated. With the bit at 1, both halves are tristated. The oscillator enables drop only once every output is at rest. When the pin goes low again, the enables come back first. After a settle interval, each output is released in the phase that matches its resting level.

Top module: `clk_park_seq`

## Requirements
- R1: After reset and until the synchronized pin has been seen low at a sampling point, a high pin is ignored: `xtal_en_o` and `vco_en_o` stay 1, `parked_o` stays 0, and all outputs keep following their sources.
- R2: A power-down request is accepted only when the synchronized pin is high at two consecutive sampling points, which are the falling edges of `dif_src_i[0]`. A high pulse shorter than one period of `dif_src_i[0]` is ignored.
- R3: After power-down is accepted, each `se_clk_o[i]` stops low only once its source is low. Every high pulse that appears has the full length of a source high phase, and the output stays low while parked.
- R4: Each differential group stops only once its true source is high, which is the complement's low phase. Every low pulse on `dif_t_o[g]` has the full length of a source low phase.
- R5: While parked, a group whose `drive_mode_i[g]` bit is 0 (bit 0 = CPU, bit 1 = SRC, bit 2 = DOT) has `dif_t_o[g]`=1, `dif_t_oe_o[g]`=1 and `dif_c_oe_o[g]`=0.
- R6: While parked, a group whose `drive_mode_i[g]` bit is 1 has `dif_t_oe_o[g]`=0 and `dif_c_oe_o[g]`=0.
- R7: `xtal_en_o` and `vco_en_o` fall only after every output is at rest. `parked_o` is 1 exactly while the enables are 0.
- R8: When the synchronized pin is low at two consecutive sampling points while parked, the enables return to 1 and `parked_o` falls. The outputs stay at rest for at least `SETTLE_CYC` cycles and then resume with full-length pulses.
- R9: During and directly after reset, both enables are 1, `parked_o` is 0, every output-enable is 1, and the outputs follow their sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ctl_pin_i | input | 1 | Asynchronous dual-role pin: power-good (low) first, then power-down request (high) |
| drive_mode_i | input | N_DIF | Per-group resting mode: 0 = true high and complement tristated, 1 = both tristated |
| se_src_i | input | N_SE | Single-ended source clocks |
| dif_src_i | input | N_DIF | True-phase source of each differential group |
| se_clk_o | output | N_SE | Gated single-ended clocks |
| dif_t_o | output | N_DIF | True output of each pair |
| dif_t_oe_o | output | N_DIF | Output-enable of each true output |
| dif_c_o | output | N_DIF | Complement output of each pair |
| dif_c_oe_o | output | N_DIF | Output-enable of each complement output |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| vco_en_o | output | 1 | VCO enable |
| parked_o | output | 1 | All outputs at rest and oscillators disabled |

## Verification
Some properties are checked by assertions on every cycle. A gate may change only in the phase that matches its resting level. The enables may be low only while every gate is closed. Resting levels must match each group's mode bit. Power-down may be taken only at a sampling point at which the pin is high. No gate opens before the settle interval is over. Other behaviour can be shown only by the bench scenarios: full-length pulses across stop and restart, rejection of short pin pulses, the pin being ignored before power-good, the settle delay as seen from the enable edge, and the resting levels in all eight combinations of mode bits.

// File: rtl/clk_park_pkg.sv
package clk_park_pkg;
   typedef enum logic [2:0] {
      SEQ_RUN,
      SEQ_STOP,
      SEQ_OFF,
      SEQ_WAKE,
      SEQ_RESUME
   } seq_state_e;
endpackage

// File: rtl/clk_park_qual.sv
module clk_park_qual #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic smp_src_i,
   output logic pg_done_o,
   output logic pd_req_o,
   output logic pd_clr_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   pin_s;
   logic                   smp_prev_q;
   logic                   smp_evt;
   logic [1:0]             hist_q;
   logic                   pg_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("clk_park_qual: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
   end

   assign pin_s   = sync_q[SYNC_STAGES-1];
   assign smp_evt = smp_prev_q & ~smp_src_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_prev_q <= 1'b0;
         hist_q     <= 2'b00;
         pg_q       <= 1'b0;
      end else begin
         smp_prev_q <= smp_src_i;
         if (smp_evt) begin
            hist_q <= {hist_q[0], pin_s};
            if (!pin_s) pg_q <= 1'b1;
         end
      end
   end

   assign pg_done_o = pg_q;
   assign pd_req_o  = pg_q & (&hist_q);
   assign pd_clr_o  = ~|hist_q;

   // R2
   pd_at_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_req_o) |-> ($past(smp_evt) && $past(pin_s)));
endmodule

// File: rtl/clk_park_gate.sv
module clk_park_gate #(
   parameter bit PARK_HIGH = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic stop_i,
   output logic run_o
);
   logic run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b1;
      end else if (src_i == PARK_HIGH) begin
         run_q <= ~stop_i;
      end
   end

   assign run_o = run_q;

   // R3 R4
   gate_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(run_q) |-> ($past(src_i) == PARK_HIGH));
endmodule

// File: rtl/clk_park_fsm.sv
module clk_park_fsm
   import clk_park_pkg::*;
#(
   parameter int SETTLE_CYC = 16,
   parameter int N_GATES    = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pg_done_i,
   input  logic               pd_req_i,
   input  logic               pd_clr_i,
   input  logic [N_GATES-1:0] gates_i,
   output logic               stop_o,
   output logic               osc_en_o,
   output logic               parked_o
);
   localparam int CNT_W = $clog2(SETTLE_CYC + 1);
   localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC);

   seq_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("clk_park_fsm: SETTLE_CYC must be at least 1");
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_RUN:    if (pd_req_i) state_d = SEQ_STOP;
         SEQ_STOP:   if (gates_i == '0) state_d = SEQ_OFF;
         SEQ_OFF:    if (pd_clr_i) state_d = SEQ_WAKE;
         SEQ_WAKE:   if (cnt_q == SETTLE_LAST) state_d = SEQ_RESUME;
         SEQ_RESUME: if (&gates_i) state_d = SEQ_RUN;
         default:    state_d = SEQ_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_RUN;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == SEQ_WAKE) cnt_q <= cnt_q + 1'b1;
         else                     cnt_q <= '0;
      end
   end

   assign stop_o   = (state_q == SEQ_STOP) || (state_q == SEQ_OFF) || (state_q == SEQ_WAKE);
   assign osc_en_o = (state_q != SEQ_OFF);
   assign parked_o = (state_q == SEQ_OFF);

   // R7
   osc_off_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en_o |-> (gates_i == '0));
   // R1
   no_pd_before_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pg_done_i |-> osc_en_o);
   // R8
   wake_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osc_en_o) |-> (stop_o && (gates_i == '0)));
endmodule

// File: rtl/clk_park_seq.sv
module clk_park_seq #(
   parameter int N_SE        = 4,
   parameter int N_DIF       = 3,
   parameter int SYNC_STAGES = 2,
   parameter int SETTLE_CYC  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_pin_i,
   input  logic [N_DIF-1:0] drive_mode_i,
   input  logic [N_SE-1:0]  se_src_i,
   input  logic [N_DIF-1:0] dif_src_i,
   output logic [N_SE-1:0]  se_clk_o,
   output logic [N_DIF-1:0] dif_t_o,
   output logic [N_DIF-1:0] dif_t_oe_o,
   output logic [N_DIF-1:0] dif_c_o,
   output logic [N_DIF-1:0] dif_c_oe_o,
   output logic             xtal_en_o,
   output logic             vco_en_o,
   output logic             parked_o
);
   localparam int N_GATES = N_SE + N_DIF;

   logic               pg_done, pd_req, pd_clr, stop, osc_en;
   logic [N_SE-1:0]    se_run;
   logic [N_DIF-1:0]   dif_run;

   generate
      if (N_SE < 1)  begin : g_bad_se  $error("clk_park_seq: N_SE must be at least 1");  end
      if (N_DIF < 1) begin : g_bad_dif $error("clk_park_seq: N_DIF must be at least 1"); end
   endgenerate

   clk_park_qual #(.SYNC_STAGES(SYNC_STAGES)) qual_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (ctl_pin_i),
      .smp_src_i (dif_src_i[0]),
      .pg_done_o (pg_done),
      .pd_req_o  (pd_req),
      .pd_clr_o  (pd_clr)
   );

   generate
      for (genvar i = 0; i < N_SE; i++) begin : g_se
         clk_park_gate #(.PARK_HIGH(1'b0)) gate_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (se_src_i[i]),
            .stop_i (stop),
            .run_o  (se_run[i])
         );
         assign se_clk_o[i] = se_src_i[i] & se_run[i];
      end
      for (genvar g = 0; g < N_DIF; g++) begin : g_dif
         clk_park_gate #(.PARK_HIGH(1'b1)) gate_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (dif_src_i[g]),
            .stop_i (stop),
            .run_o  (dif_run[g])
         );
         assign dif_t_o[g]    = dif_run[g] ? dif_src_i[g] : 1'b1;
         assign dif_t_oe_o[g] = dif_run[g] | ~drive_mode_i[g];
         assign dif_c_o[g]    = dif_run[g] & ~dif_src_i[g];
         assign dif_c_oe_o[g] = dif_run[g];

         // R5
         park_mode0_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (parked_o && !drive_mode_i[g]) |-> (dif_t_o[g] && dif_t_oe_o[g] && !dif_c_oe_o[g]));
         // R6
         park_mode1_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (parked_o && drive_mode_i[g]) |-> (!dif_t_oe_o[g] && !dif_c_oe_o[g]));
      end
   endgenerate

   clk_park_fsm #(.SETTLE_CYC(SETTLE_CYC), .N_GATES(N_GATES)) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pg_done_i (pg_done),
      .pd_req_i  (pd_req),
      .pd_clr_i  (pd_clr),
      .gates_i   ({dif_run, se_run}),
      .stop_o    (stop),
      .osc_en_o  (osc_en),
      .parked_o  (parked_o)
   );

   assign xtal_en_o = osc_en;
   assign vco_en_o  = osc_en;

   // R3
   se_parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      parked_o |-> (se_clk_o == '0));
endmodule

// File: tb/clk_park_seq_tb_top.sv
module clk_park_seq_tb_top;
   localparam int N_SE   = 4;
   localparam int N_DIF  = 3;
   localparam int SETTLE = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pin = 1'b1;
   logic [N_DIF-1:0] mode = '0;
   logic [N_SE-1:0]  se_src = '0;
   logic [N_DIF-1:0] dif_src = '0;
   logic [N_SE-1:0]  se_clk_o;
   logic [N_DIF-1:0] dif_t_o, dif_t_oe_o, dif_c_o, dif_c_oe_o;
   logic             xtal_en_o, vco_en_o, parked_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit mon_on = 0;
   bit saw_park = 0;

   int se_cnt [N_SE];
   int dif_cnt [N_DIF];

   always #4 clk = ~clk;

   clk_park_seq #(.N_SE(N_SE), .N_DIF(N_DIF), .SYNC_STAGES(2), .SETTLE_CYC(SETTLE)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_pin_i(pin), .drive_mode_i(mode),
      .se_src_i(se_src), .dif_src_i(dif_src), .se_clk_o(se_clk_o),
      .dif_t_o(dif_t_o), .dif_t_oe_o(dif_t_oe_o), .dif_c_o(dif_c_o), .dif_c_oe_o(dif_c_oe_o),
      .xtal_en_o(xtal_en_o), .vco_en_o(vco_en_o), .parked_o(parked_o)
   );

   // source clocks: single-ended i has half period i+2, group g has half period g+3
   initial begin
      for (int i = 0; i < N_SE; i++) se_cnt[i] = 0;
      for (int g = 0; g < N_DIF; g++) dif_cnt[g] = 0;
   end

   always @(posedge clk) begin
      for (int i = 0; i < N_SE; i++) begin
         if (se_cnt[i] == i + 1) begin se_cnt[i] <= 0; se_src[i] <= ~se_src[i]; end
         else se_cnt[i] <= se_cnt[i] + 1;
      end
      for (int g = 0; g < N_DIF; g++) begin
         if (dif_cnt[g] == g + 2) begin dif_cnt[g] <= 0; dif_src[g] <= ~dif_src[g]; end
         else dif_cnt[g] <= dif_cnt[g] + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // pulse-length monitor and enable-order monitor
   logic [N_SE-1:0]  se_prev = '0;
   logic [N_DIF-1:0] t_prev = '1;
   int  se_len [N_SE];
   bit  se_go [N_SE];
   int  t_len [N_DIF];
   bit  t_go [N_DIF];

   always @(negedge clk) begin
      if (mon_on) begin
         if (parked_o) saw_park = 1;
         for (int i = 0; i < N_SE; i++) begin
            if (se_clk_o[i]) begin
               if (!se_prev[i]) begin se_go[i] = 1; se_len[i] = 0; end
               se_len[i]++;
            end else if (se_prev[i] && se_go[i]) begin
               chk(se_len[i] == i + 2, "R3 se high pulse length", se_len[i], i + 2);
            end
         end
         for (int g = 0; g < N_DIF; g++) begin
            if (!dif_t_o[g]) begin
               if (t_prev[g]) begin t_go[g] = 1; t_len[g] = 0; end
               t_len[g]++;
            end else if (!t_prev[g] && t_go[g]) begin
               chk(t_len[g] == g + 3, "R4 true low pulse length", t_len[g], g + 3);
            end
         end
         if (!vco_en_o || !xtal_en_o) begin
            chk(se_clk_o == '0, "R7 se at rest while enables low", int'(se_clk_o), 0);
            chk(!dif_c_oe_o, "R7 complements off while enables low", int'(dif_c_oe_o), 0);
            chk(parked_o == 1'b1, "R7 parked_o while enables low", parked_o, 1);
         end else begin
            chk(parked_o == 1'b0, "R7 parked_o low while enabled", parked_o, 0);
         end
      end
      se_prev = se_clk_o;
      t_prev  = dif_t_o;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wait_cyc(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < N_SE; i++) begin se_len[i] = 0; se_go[i] = 0; end
      for (int g = 0; g < N_DIF; g++) begin t_len[g] = 0; t_go[g] = 0; end
      wait_cyc(5);
      // R9 reset state
      chk(vco_en_o && xtal_en_o, "R9 enables in reset", vco_en_o, 1);
      chk(!parked_o, "R9 parked_o in reset", parked_o, 0);
      chk(dif_t_oe_o == '1 && dif_c_oe_o == '1, "R9 oe in reset", int'({dif_t_oe_o, dif_c_oe_o}), 63);
      chk(se_clk_o == se_src, "R9 se follows source", int'(se_clk_o), int'(se_src));
      rst_n = 1'b1;
      mon_on = 1;
      @(negedge clk);
      chk(vco_en_o && !parked_o, "R9 state after reset", parked_o, 0);
      chk(dif_t_o == dif_src, "R9 true follows source", int'(dif_t_o), int'(dif_src));

      // R1: pin high (power not yet good) is ignored
      wait_cyc(120);
      chk(!saw_park, "R1 no park before power-good", saw_park, 0);
      chk(vco_en_o && xtal_en_o, "R1 enables before power-good", vco_en_o, 1);
      pin = 1'b0;
      wait_cyc(30);

      // R2: short high pulses are rejected
      pin = 1'b1; wait_cyc(1); pin = 1'b0;
      wait_cyc(60);
      pin = 1'b1; wait_cyc(4); pin = 1'b0;
      wait_cyc(60);
      chk(!saw_park, "R2 short pulse ignored", saw_park, 0);
      chk(vco_en_o, "R2 enables after short pulse", vco_en_o, 1);

      // sweep every mode combination
      for (int m = 0; m < (1 << N_DIF); m++) begin
         int dly;
         mode = m[N_DIF-1:0];
         wait_cyc(7);
         pin = 1'b1;
         dly = 0;
         while (!parked_o && dly < 200) begin @(negedge clk); dly++; end
         chk(parked_o, "R2 power-down accepted", dly, 200);
         chk(dly > 6, "R2 two sampling points needed", dly, 7);
         chk(se_clk_o == '0, "R3 se parked low", int'(se_clk_o), 0);
         for (int g = 0; g < N_DIF; g++) begin
            if (!m[g]) begin
               chk(dif_t_o[g] && dif_t_oe_o[g], "R5 true driven high", int'({dif_t_o[g], dif_t_oe_o[g]}), 3);
               chk(!dif_c_oe_o[g], "R5 complement tristated", dif_c_oe_o[g], 0);
            end else begin
               chk(!dif_t_oe_o[g] && !dif_c_oe_o[g], "R6 pair tristated",
                   int'({dif_t_oe_o[g], dif_c_oe_o[g]}), 0);
            end
         end
         chk(!vco_en_o && !xtal_en_o, "R7 enables off when parked", int'({vco_en_o, xtal_en_o}), 0);
         wait_cyc(25);
         chk(parked_o && se_clk_o == '0, "R3 stays parked", int'(se_clk_o), 0);
         // R8 wake
         pin = 1'b0;
         dly = 0;
         while (!vco_en_o && dly < 200) begin @(negedge clk); dly++; end
         chk(vco_en_o && xtal_en_o, "R8 enables return", vco_en_o, 1);
         chk(!parked_o, "R8 parked_o falls", parked_o, 0);
         dly = 0;
         while (!se_clk_o[0] && dly < 300) begin @(negedge clk); dly++; end
         chk(dly >= SETTLE, "R8 settle before release", dly, SETTLE);
         wait_cyc(40);
         chk(dif_t_oe_o == '1 && dif_c_oe_o == '1, "R8 outputs driven after release",
             int'({dif_t_oe_o, dif_c_oe_o}), 63);
      end

      wait_cyc(20);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule